// File: doc/BRIEF.md
# Prioritized Interrupt Distributor

This block gathers a set of interrupt sources and delivers each one to up to four processor cores. Each source has a pending flag, an active flag, an enable, a 4-bit urgency level (a lower number is more urgent), a trigger kind (level or rising edge) and a bit mask that names the cores it may reach. Each core has a 4-bit threshold. A core's IRQ line is high while at least one source qualifies for it. A source qualifies when it is enabled, pending, not active, aimed at that core, and its level is strictly below that core's threshold.

Software programs sources and thresholds through a flat register port. A core takes the interrupt it is being shown with a one-cycle acknowledge strobe. The same cycle the port returns the chosen ID, and the clock edge clears that source's pending flag and sets its active flag. An end-of-interrupt strobe carrying an ID clears that source's active flag. Because the compare is strict, a level of 15 can never raise an IRQ. A source whose core mask is zero is held but never delivered.

Top module: `idist_top`

## Requirements
- R1: After reset, every source reads back enable 0, edge mode 0, level 8, core mask 4'b0001, pending 0 and active 0. Every core threshold reads 15 and every cpu_irq bit is 0.
- R2: cpu_irq[c] is high only when a qualifying source has a level strictly below threshold c. A level equal to the threshold does not raise the line.
- R3: A source with level 15 never raises any cpu_irq bit, whatever the threshold.
- R4: A source raises cpu_irq[c] only if bit c of its core mask is 1. A zero mask delivers to no core.
- R5: ack_id names the qualifying source for core ack_cpu that has the lowest level. On a tie in level, the lowest index wins.
- R6: An acknowledge that finds a source clears that source's pending bit and sets its active bit at the clock edge. With no qualifying source, ack_id is 1023 and the acknowledge changes no state.
- R7: An active source is not shown to any core. An end-of-interrupt strobe with its ID clears the active bit. An ID of N_SRC or more is ignored.
- R8: A level source sets pending on every clock edge where its input is high, so it pends again after an acknowledge while the input stays high. An acknowledge wins over the set in the same cycle.
- R9: An edge source sets pending only on a clock edge where its input is 1 and was 0 at the previous edge. An input that is held high does not pend again.
- R10: A source with enable 0 still latches pending but raises no IRQ and is never acknowledged.
- R11: Register layout. Address bit IDX_W = 0 selects source reg_addr[IDX_W-1:0]. The write data is [0] enable, [1] edge mode, [5:2] level, [9:6] core mask. The read data is the same fields plus [10] pending and [11] active. Address bit IDX_W = 1 selects the threshold of core reg_addr[1:0], held in data bits [3:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_in | input | N_SRC | Interrupt source inputs |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | IDX_W+1 | Register address |
| reg_wdata | input | 10 | Register write data |
| reg_rdata | output | 12 | Register read data (combinational) |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_cpu | input | 2 | Core that acknowledges |
| ack_id | output | 10 | ID returned to the acknowledging core, 1023 for none |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_id | input | 10 | ID whose active bit is cleared |
| cpu_irq | output | 4 | IRQ line for each core |

## Verification
A pending or active bit that is wrong shows at the ports in the same cycle. cpu_irq takes the wrong value, or ack_id names a different source, and a register read of that source disagrees at once. An off-by-one in the strict compare appears as soon as a level equals a threshold. A stuck active bit appears at the next acknowledge: the returned ID skips the source, or the ID is 1023 when the source should be returned. A wrong edge history shows up one edge after an input is held high, as an extra pend.

// File: rtl/idist_pkg.sv
// Shared constants and the per-source configuration record.
// Assumes exactly four cores and 4-bit levels.
package idist_pkg;
    localparam int PRIO_W    = 4;
    localparam int CPU_N     = 4;
    localparam int CPU_SEL_W = 2;
    localparam int ID_W      = 10;
    localparam int ID_NONE   = 1023;
    localparam int CFG_W     = 2 + PRIO_W + CPU_N;

    typedef struct packed {
        logic [CPU_N-1:0]  tgt;
        logic [PRIO_W-1:0] prio;
        logic              edge_md;
        logic              en;
    } src_cfg_t;

    localparam src_cfg_t CFG_DFLT = '{tgt: 4'b0001, prio: 4'd8, edge_md: 1'b0, en: 1'b0};
    localparam logic [PRIO_W-1:0] MASK_DFLT = 4'hF;
endpackage

// File: rtl/idist_src_bank.sv
// Per-source state: configuration, pending and active flags, edge history.
// Assumes ack_clr and eoi_clr are one-hot or zero.
module idist_src_bank
    import idist_pkg::*;
#(
    parameter int N_SRC = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_SRC-1:0]     src_in,
    input  logic [N_SRC-1:0]     cfg_we,
    input  logic [CFG_W-1:0]     cfg_wdata,
    input  logic [N_SRC-1:0]     ack_clr,
    input  logic [N_SRC-1:0]     eoi_clr,
    output src_cfg_t [N_SRC-1:0] cfg,
    output logic [N_SRC-1:0]     pend,
    output logic [N_SRC-1:0]     act
);
    logic [N_SRC-1:0] prev_q;

    // Remembers each input from the last edge so rising edges can be found.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= src_in;
    end

    for (genvar gi = 0; gi < N_SRC; gi++) begin : g_src
        logic set_w;
        assign set_w = cfg[gi].edge_md ? (src_in[gi] & ~prev_q[gi]) : src_in[gi];

        // Holds the programmed configuration of this source.
        always_ff @(posedge clk) begin
            if (!rst_n)          cfg[gi] <= CFG_DFLT;
            else if (cfg_we[gi]) cfg[gi] <= src_cfg_t'(cfg_wdata);
        end

        // Pending: an acknowledge clears it, otherwise a trigger sets it.
        always_ff @(posedge clk) begin
            if (!rst_n)           pend[gi] <= 1'b0;
            else if (ack_clr[gi]) pend[gi] <= 1'b0;
            else if (set_w)       pend[gi] <= 1'b1;
        end

        // Active: an acknowledge sets it, an end-of-interrupt clears it.
        always_ff @(posedge clk) begin
            if (!rst_n)           act[gi] <= 1'b0;
            else if (ack_clr[gi]) act[gi] <= 1'b1;
            else if (eoi_clr[gi]) act[gi] <= 1'b0;
        end
    end
endmodule

// File: rtl/idist_pick.sv
// Chooses the most urgent qualifying source for one core.
// Strict compare: the level must be below the threshold. Ties go to the lower index.
module idist_pick
    import idist_pkg::*;
#(
    parameter int N_SRC = 8,
    parameter int CORE  = 0,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  src_cfg_t [N_SRC-1:0] cfg,
    input  logic [N_SRC-1:0]     pend,
    input  logic [N_SRC-1:0]     act,
    input  logic [PRIO_W-1:0]    mask,
    output logic                 found,
    output logic [IDX_W-1:0]     idx
);
    logic [PRIO_W-1:0] best;

    // Linear scan with a shrinking bound, so equal levels keep the first index.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = mask;
        for (int i = 0; i < N_SRC; i++) begin
            if (cfg[i].en && pend[i] && !act[i] && cfg[i].tgt[CORE] && (cfg[i].prio < best)) begin
                found = 1'b1;
                idx   = IDX_W'(i);
                best  = cfg[i].prio;
            end
        end
    end
endmodule

// File: rtl/idist_top.sv
// Interrupt distributor top: register port, per-core thresholds, pickers,
// acknowledge and end-of-interrupt. Assumes N_SRC is a power of two from 4 to 512.
module idist_top
    import idist_pkg::*;
#(
    parameter int N_SRC = 8,
    localparam int IDX_W  = $clog2(N_SRC),
    localparam int ADDR_W = IDX_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_SRC-1:0]     src_in,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [CFG_W-1:0]     reg_wdata,
    output logic [CFG_W+1:0]     reg_rdata,
    input  logic                 ack_valid,
    input  logic [CPU_SEL_W-1:0] ack_cpu,
    output logic [ID_W-1:0]      ack_id,
    input  logic                 eoi_valid,
    input  logic [ID_W-1:0]      eoi_id,
    output logic [CPU_N-1:0]     cpu_irq
);
    logic [CPU_N-1:0][PRIO_W-1:0] mask_q;
    src_cfg_t [N_SRC-1:0]         cfg_v;
    logic [N_SRC-1:0]             pend_v, act_v, cfg_we, ack_clr, eoi_clr;
    logic [CPU_N-1:0]             found_v;
    logic [CPU_N-1:0][IDX_W-1:0]  idx_v;
    logic                         sel_mask;

    assign sel_mask = reg_addr[ADDR_W-1];

    // Decodes a write to one source configuration word.
    always_comb begin
        for (int i = 0; i < N_SRC; i++)
            cfg_we[i] = reg_we && !sel_mask && (reg_addr[IDX_W-1:0] == IDX_W'(i));
    end

    // Holds the per-core thresholds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < CPU_N; c++) mask_q[c] <= MASK_DFLT;
        end else if (reg_we && sel_mask) begin
            mask_q[reg_addr[CPU_SEL_W-1:0]] <= reg_wdata[PRIO_W-1:0];
        end
    end

    idist_src_bank #(.N_SRC(N_SRC)) u_bank (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .cfg_we(cfg_we),
        .cfg_wdata(reg_wdata), .ack_clr(ack_clr), .eoi_clr(eoi_clr),
        .cfg(cfg_v), .pend(pend_v), .act(act_v)
    );

    for (genvar gc = 0; gc < CPU_N; gc++) begin : g_core
        idist_pick #(.N_SRC(N_SRC), .CORE(gc)) u_pick (
            .cfg(cfg_v), .pend(pend_v), .act(act_v), .mask(mask_q[gc]),
            .found(found_v[gc]), .idx(idx_v[gc])
        );
    end

    assign cpu_irq = found_v;

    // Returns the chosen ID and forms the one-hot clear for the acknowledge.
    always_comb begin
        ack_id  = found_v[ack_cpu] ? ID_W'(idx_v[ack_cpu]) : ID_W'(ID_NONE);
        ack_clr = (ack_valid && found_v[ack_cpu]) ? (N_SRC'(1) << idx_v[ack_cpu]) : '0;
    end

    // Forms the one-hot end-of-interrupt clear and drops IDs that are out of range.
    always_comb begin
        eoi_clr = (eoi_valid && (eoi_id < ID_W'(N_SRC))) ? (N_SRC'(1) << eoi_id[IDX_W-1:0]) : '0;
    end

    // Read mux: a core threshold or a source word with its status.
    always_comb begin
        if (sel_mask)
            reg_rdata = (CFG_W+2)'(mask_q[reg_addr[CPU_SEL_W-1:0]]);
        else
            reg_rdata = {act_v[reg_addr[IDX_W-1:0]], pend_v[reg_addr[IDX_W-1:0]],
                         CFG_W'(cfg_v[reg_addr[IDX_W-1:0]])};
    end
endmodule

// File: rtl/idist_chk.sv
// Temporal checks on the distributor, attached by bind.
// Assumes the default port widths of idist_top.
module idist_chk
    import idist_pkg::*;
#(
    parameter int N_SRC = 8,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         ack_valid,
    input logic [ID_W-1:0]              ack_id,
    input logic                         eoi_valid,
    input logic [ID_W-1:0]              eoi_id,
    input logic [CPU_N-1:0]             cpu_irq,
    input logic [N_SRC-1:0]             act_v,
    input logic [CPU_N-1:0][PRIO_W-1:0] mask_q
);
    // R6: a successful acknowledge leaves the source active.
    p_ack_sets_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_id != ID_W'(ID_NONE) && !(eoi_valid && eoi_id == ack_id))
        |=> act_v[$past(ack_id[IDX_W-1:0])]);

    // R6: an acknowledge that finds nothing changes no active bit.
    p_empty_ack_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_id == ID_W'(ID_NONE) && !eoi_valid) |=> $stable(act_v));

    // R7: an end-of-interrupt for an in-range ID clears its active bit.
    p_eoi_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_valid && eoi_id < ID_W'(N_SRC) && !(ack_valid && ack_id == eoi_id))
        |=> !act_v[$past(eoi_id[IDX_W-1:0])]);

    // R5: a returned ID is either a real source or the empty code.
    p_ack_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> (ack_id < ID_W'(N_SRC) || ack_id == ID_W'(ID_NONE)));

    for (genvar gc = 0; gc < CPU_N; gc++) begin : g_c
        // R2: a zero threshold lets no level through.
        p_zero_mask_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
            cpu_irq[gc] |-> (mask_q[gc] != '0));
    end
endmodule

bind idist_top idist_chk #(.N_SRC(N_SRC)) u_chk (
    .clk(clk), .rst_n(rst_n), .ack_valid(ack_valid), .ack_id(ack_id),
    .eoi_valid(eoi_valid), .eoi_id(eoi_id), .cpu_irq(cpu_irq),
    .act_v(act_v), .mask_q(mask_q)
);

// File: tb/sim_idist_top.sv
module sim_idist_top;
    import idist_pkg::*;
    localparam int N = 8;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, reg_we, ack_valid, eoi_valid;
    logic [N-1:0] src_in;
    logic [3:0]   reg_addr;
    logic [9:0]   reg_wdata;
    logic [11:0]  reg_rdata;
    logic [1:0]   ack_cpu;
    logic [9:0]   ack_id, eoi_id;
    logic [3:0]   cpu_irq;

    idist_top #(.N_SRC(N)) u0 (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ack_valid(ack_valid), .ack_cpu(ack_cpu),
        .ack_id(ack_id), .eoi_valid(eoi_valid), .eoi_id(eoi_id), .cpu_irq(cpu_irq)
    );

    int n_run = 0, n_fail = 0;
    logic m_en[N], m_edge[N], m_pend[N], m_act[N], m_prev[N];
    logic [3:0] m_prio[N], m_tgt[N], m_mask[4];
    logic [N-1:0] sv;

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int m_pick(input int c);
        int id = -1;
        logic [3:0] best = m_mask[c];
        for (int i = 0; i < N; i++)
            if (m_en[i] && m_pend[i] && !m_act[i] && m_tgt[i][c] && m_prio[i] < best) begin
                id = i; best = m_prio[i];
            end
        return id;
    endfunction

    function automatic int m_irq();
        int v = 0;
        for (int c = 0; c < 4; c++) if (m_pick(c) >= 0) v |= (1 << c);
        return v;
    endfunction

    function automatic int m_read(input int a);
        if (a[3]) return int'(m_mask[a[1:0]]);
        return {m_act[a[2:0]], m_pend[a[2:0]], m_tgt[a[2:0]], m_prio[a[2:0]], m_edge[a[2:0]], m_en[a[2:0]]};
    endfunction

    function automatic int cw(input int en, input int ed, input int pr, input int tg);
        return (tg << 6) | (pr << 2) | (ed << 1) | en;
    endfunction

    task automatic m_reset();
        for (int i = 0; i < N; i++) begin
            m_en[i] = 0; m_edge[i] = 0; m_pend[i] = 0; m_act[i] = 0; m_prev[i] = 0;
            m_prio[i] = 4'd8; m_tgt[i] = 4'b0001;
        end
        for (int c = 0; c < 4; c++) m_mask[c] = 4'hF;
    endtask

    // One cycle: drive, compare outputs before the edge, advance the model at the edge.
    task automatic tick(input logic av, input int ac, input logic ev, input int ei,
                        input logic we, input int ad, input int wd, output int got_id);
        int pk;
        @(negedge clk);
        src_in = sv; ack_valid = av; ack_cpu = 2'(ac); eoi_valid = ev; eoi_id = 10'(ei);
        reg_we = we; reg_addr = 4'(ad); reg_wdata = 10'(wd);
        #1;
        check("R2/R3/R4/R10 cpu_irq", int'(cpu_irq), m_irq());
        got_id = int'(ack_id);
        pk = av ? m_pick(ac) : -1;
        if (av) check("R5/R6 ack_id", int'(ack_id), (pk < 0) ? ID_NONE : pk);
        @(posedge clk);
        for (int i = 0; i < N; i++) begin
            logic set = m_edge[i] ? (sv[i] && !m_prev[i]) : sv[i];
            if (pk == i) begin m_pend[i] = 0; m_act[i] = 1; end
            else begin
                if (set) m_pend[i] = 1;
                if (ev && ei == i) m_act[i] = 0;
            end
            m_prev[i] = sv[i];
        end
        if (we) begin
            if (ad[3]) m_mask[ad[1:0]] = 4'(wd);
            else begin
                m_en[ad[2:0]] = wd[0]; m_edge[ad[2:0]] = wd[1];
                m_prio[ad[2:0]] = 4'(wd >> 2); m_tgt[ad[2:0]] = 4'(wd >> 6);
            end
        end
        #1;
        reg_we = 0; ack_valid = 0; eoi_valid = 0;
    endtask

    task automatic idle(); int d; tick(0, 0, 0, 0, 0, 0, 0, d); endtask
    task automatic wr(input int a, input int d); int x; tick(0, 0, 0, 0, 1, a, d, x); endtask
    task automatic ack(input int c, output int id); tick(1, c, 0, 0, 0, 0, 0, id); endtask
    task automatic eoi(input int i); int x; tick(0, 0, 1, i, 0, 0, 0, x); endtask

    task automatic rd(input int a, output int v);
        reg_addr = 4'(a); #1; v = int'(reg_rdata);
        check("R11 readback", v, m_read(a));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int v, id;
        void'($urandom(32'h1D57));
        rst_n = 0; sv = '0; src_in = '0; reg_we = 0; reg_addr = '0; reg_wdata = '0;
        ack_valid = 0; ack_cpu = '0; eoi_valid = 0; eoi_id = '0;
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;

        // R1: reset values
        #1;
        check("R1 cpu_irq", int'(cpu_irq), 0);
        for (int i = 0; i < N; i++) begin rd(i, v); check("R1 source word", v, 12'h060); end
        for (int c = 0; c < 4; c++) begin rd(8 + c, v); check("R1 threshold", v, 15); end

        // R2: strict compare against the threshold
        wr(0, cw(1, 0, 8, 1)); sv[0] = 1; idle();
        check("R2 level 8 under 15", int'(cpu_irq[0]), 1);
        wr(8, 8);  check("R2 level equal threshold", int'(cpu_irq[0]), 0);
        wr(8, 9);  check("R2 level below threshold", int'(cpu_irq[0]), 1);
        wr(8, 0);  check("R2 zero threshold", int'(cpu_irq[0]), 0);
        // R3: level 15 never signals
        wr(8, 15); wr(0, cw(1, 0, 15, 1));
        check("R3 level 15", int'(cpu_irq), 0);
        // R4: core mask routing
        wr(0, cw(1, 0, 2, 0));  check("R4 zero core mask", int'(cpu_irq), 0);
        wr(0, cw(1, 0, 2, 4));  check("R4 core 2 only", int'(cpu_irq), 4);
        // R10: disabled source is latched but silent
        wr(0, cw(0, 0, 2, 4));  check("R10 disabled", int'(cpu_irq), 0);
        rd(0, v); check("R10 still pending", (v >> 10) & 1, 1);
        sv[0] = 0; ack(2, id); check("R10 not acked", id, ID_NONE);

        // R5: lowest level wins, then lowest index
        wr(1, cw(1, 0, 3, 1)); wr(2, cw(1, 0, 3, 1)); wr(0, cw(1, 0, 5, 1));
        sv[2:0] = 3'b111; idle();
        ack(0, id); check("R5 tie to lowest index", id, 1);
        rd(1, v); check("R6 active set", (v >> 11) & 1, 1);
        idle(); rd(1, v); check("R8 level pends again", (v >> 10) & 1, 1);
        ack(0, id); check("R7 active skipped", id, 2);
        ack(0, id); check("R5 next level", id, 0);
        ack(0, id); check("R6 nothing qualifies", id, ID_NONE);
        eoi(9); ack(0, id); check("R7 out of range end ignored", id, ID_NONE);
        eoi(1); ack(0, id); check("R7 end re-enables", id, 1);
        sv[2:0] = 3'b000; eoi(0); eoi(1); eoi(2);

        // R9: edge sources pend once per rising edge
        wr(3, cw(1, 1, 1, 1)); sv[3] = 1; idle();
        ack(0, id); check("R9 edge pends", id, 3);
        idle(); idle(); rd(3, v); check("R9 held high no re-pend", (v >> 10) & 1, 0);
        sv[3] = 0; idle(); sv[3] = 1; idle();
        rd(3, v); check("R9 new edge pends", (v >> 10) & 1, 1);

        // Random phase against the model
        for (int k = 0; k < 4000; k++) begin
            int r = int'($urandom_range(0, 99));
            for (int i = 0; i < N; i++) if ($urandom_range(0, 9) == 0) sv[i] = ~sv[i];
            if (r < 10)
                tick(0, 0, 0, 0, 1, int'($urandom_range(0, 11)), int'($urandom_range(0, 1023)), id);
            else if (r < 40)
                tick(1, int'($urandom_range(0, 3)), 0, 0, 0, 0, 0, id);
            else if (r < 60)
                tick(0, 0, 1, int'($urandom_range(0, N)), 0, 0, 0, id);
            else if (r < 70)
                tick(1, int'($urandom_range(0, 3)), 1, int'($urandom_range(0, N - 1)), 0, 0, 0, id);
            else
                idle();
            if (k % 16 == 0) rd(int'($urandom_range(0, 11)), v);
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule